// File: doc/BRIEF.md
# Buffer Descriptor Ring Controller

This block holds one table of 32-bit buffer descriptors that serves both the transmit and the receive direction. A host fills and inspects the table through a small register bus, one word per access. A programmable boundary register divides the table. The transmit ring starts at entry 0 and uses the entries below the boundary. The receive ring starts at the boundary entry and uses the entries from there upward.

Each direction has its own ring pointer. The block shows the descriptor at that pointer to a consumer, for example a DMA engine, and flags it valid when the descriptor's ready bit is set. When the consumer signals completion, the block writes the descriptor back with the ready bit cleared and the consumed length stored. The pointer then advances to the next entry. If the descriptor's wrap bit is set, the pointer returns to the start of its ring instead, so the wrap bit alone sets the ring length.

Descriptor word layout: bits 31:16 hold the length, bit 15 is ready, bit 14 is wrap, bit 13 requests a pause control frame (transmit only), and bits 12:0 are free for software.

Top module: `bdring_ctrl`

## Requirements
- R1: After synchronous reset, the transmit index is 0 and the receive index is 0x80. Both valid outputs are 0, every table word reads 0, and the boundary register reads 0x80.
- R2: A host access is a one-cycle `hst_sel` pulse. `hst_ack` is 1 exactly in the following cycle. A table access selects word index `hst_addr[9:2]`, and read data appears on `hst_rdata` together with the ack.
- R3: A register-space write (`hst_reg`=1) loads the boundary from `hst_wdata[7:0]` and moves the receive index to the new boundary in the next cycle. A register-space read returns the boundary zero-extended to 32 bits.
- R4: Each direction presents the word at its index on `*_desc`. `*_vld` is 1 only when bit 15 of that word is 1 and no write-back for that direction is pending. `tx_pause` equals bit 13 of the transmit word while `tx_vld` is 1.
- R5: A `*_done` pulse while `*_vld` is 1 rewrites the current entry with bit 15 cleared, bits 31:16 set to `*_len`, and bits 14:0 unchanged. A `*_done` while `*_vld` is 0 changes nothing.
- R6: On write-back, the index moves to index+1 (modulo the table size). If bit 14 of the written entry is set, it moves instead to the ring start: 0 for transmit, the boundary for receive.
- R7: In the cycle after an accepted `*_done`, that direction's `*_vld` is 0. Without conflicts the write-back and the index step land one cycle later.
- R8: A host table write takes the single write port before any write-back, delaying it by one cycle. When both directions have a pending write-back, transmit is written first and receive one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_sel | input | 1 | Host access request, one-cycle pulse |
| hst_we | input | 1 | Host access is a write |
| hst_reg | input | 1 | 1 selects the boundary register, 0 the descriptor table |
| hst_addr | input | IDX_W+2 | Host byte address; word index in bits IDX_W+1:2 |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, valid with hst_ack |
| hst_ack | output | 1 | Access acknowledge, one cycle after hst_sel |
| tx_vld | output | 1 | Transmit descriptor ready for use |
| tx_desc | output | 32 | Word at the transmit index |
| tx_idx | output | IDX_W | Transmit ring index |
| tx_pause | output | 1 | Current transmit descriptor asks for a pause frame |
| tx_done | input | 1 | Transmit descriptor consumed |
| tx_len | input | 16 | Length to store on transmit write-back |
| rx_vld | output | 1 | Receive descriptor ready for use |
| rx_desc | output | 32 | Word at the receive index |
| rx_idx | output | IDX_W | Receive ring index |
| rx_done | input | 1 | Receive descriptor consumed |
| rx_len | input | 16 | Length to store on receive write-back |

## Verification
The bench builds the block with its defaults: an 8-bit index, so the word index is taken from address bits 9:2 over a 256-entry table, and a reset boundary of 0x80. These values exercise the default split and four-entry rings that wrap on their fourth descriptor. The bench then moves the boundary to 0x40 while running, which covers boundary reload and a receive ring away from its reset position. The directed cases place a host write on top of a pending write-back and give both directions a completion in the same cycle. Randomised traffic then mixes ready and not-ready entries with ignored completions.

// File: rtl/bdr_pkg.sv
`timescale 1ns/1ps
package bdr_pkg;

    localparam int NCH   = 2;
    localparam int CH_TX = 0;
    localparam int CH_RX = 1;

    typedef struct packed {
        logic [15:0] len;
        logic        rdy;
        logic        wrap;
        logic        pause;
        logic [12:0] tag;
    } bd_word_t;

    // Word written back when a consumer finishes with a descriptor.
    function automatic bd_word_t retire(bd_word_t w, logic [15:0] used);
        bd_word_t r;
        r     = w;
        r.len = used;
        r.rdy = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/bdr_table.sv
`timescale 1ns/1ps
module bdr_table
    import bdr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  bd_word_t                   wr_word,
    input  logic [NCH-1:0][IDX_W-1:0]  rd_idx,
    output bd_word_t [NCH-1:0]         rd_word,
    input  logic [IDX_W-1:0]           hrd_idx,
    output bd_word_t                   hrd_word
);
    localparam int DEPTH = 1 << IDX_W;

    bd_word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_word;
        end
    end

    for (genvar c = 0; c < NCH; c++) begin : g_rd
        assign rd_word[c] = mem[rd_idx[c]];
    end

    assign hrd_word = mem[hrd_idx];

endmodule

// File: rtl/bdr_ring.sv
`timescale 1ns/1ps
module bdr_ring
    import bdr_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int RST_HOME = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] home,
    input  logic             home_load,
    input  logic [IDX_W-1:0] load_val,
    input  bd_word_t         cur,
    input  logic             done,
    input  logic [15:0]      done_len,
    input  logic             gnt,
    output logic [IDX_W-1:0] ptr,
    output logic             vld,
    output logic             pend,
    output logic [IDX_W-1:0] pend_idx,
    output bd_word_t         pend_word
);
    localparam logic [IDX_W-1:0] HOME0 = IDX_W'(RST_HOME);

    assign vld = ~pend & cur.rdy;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr       <= HOME0;
            pend      <= 1'b0;
            pend_idx  <= '0;
            pend_word <= '0;
        end else begin
            if (gnt) begin
                pend <= 1'b0;
                ptr  <= pend_word.wrap ? home : pend_idx + 1'b1;
            end
            if (done && vld) begin
                pend      <= 1'b1;
                pend_idx  <= ptr;
                pend_word <= retire(cur, done_len);
            end
            if (home_load) begin
                ptr <= load_val;
            end
        end
    end

endmodule

// File: rtl/bdring_ctrl.sv
`timescale 1ns/1ps
module bdring_ctrl
    import bdr_pkg::*;
#(
    parameter int IDX_W    = 8,
    parameter int RST_BASE = 'h80
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hst_sel,
    input  logic              hst_we,
    input  logic              hst_reg,
    input  logic [IDX_W+1:0]  hst_addr,
    input  logic [31:0]       hst_wdata,
    output logic [31:0]       hst_rdata,
    output logic              hst_ack,
    output logic              tx_vld,
    output logic [31:0]       tx_desc,
    output logic [IDX_W-1:0]  tx_idx,
    output logic              tx_pause,
    input  logic              tx_done,
    input  logic [15:0]       tx_len,
    output logic              rx_vld,
    output logic [31:0]       rx_desc,
    output logic [IDX_W-1:0]  rx_idx,
    input  logic              rx_done,
    input  logic [15:0]       rx_len
);
    localparam logic [IDX_W-1:0] BASE0 = IDX_W'(RST_BASE);

    logic                      hst_twr, base_wr;
    logic [IDX_W-1:0]          hidx, rx_base;
    logic [NCH-1:0]            wb_pend, wb_gnt, wb_wrap, ch_vld, ch_done;
    logic [NCH-1:0][IDX_W-1:0] ch_ptr, ch_pidx, ch_home;
    logic [NCH-1:0][15:0]      ch_len;
    bd_word_t [NCH-1:0]        ch_cur, ch_pword;
    bd_word_t                  host_word, wr_word;
    logic                      wr_en;
    logic [IDX_W-1:0]          wr_idx;

    assign hidx    = hst_addr[IDX_W+1:2];
    assign hst_twr = hst_sel & hst_we & ~hst_reg;
    assign base_wr = hst_sel & hst_we &  hst_reg;

    always_ff @(posedge clk) begin
        if (rst)          rx_base <= BASE0;
        else if (base_wr) rx_base <= hst_wdata[IDX_W-1:0];
    end

    // Single write port: host, then transmit write-back, then receive.
    assign wb_gnt[CH_TX] = wb_pend[CH_TX] & ~hst_twr;
    assign wb_gnt[CH_RX] = wb_pend[CH_RX] & ~hst_twr & ~wb_pend[CH_TX];

    always_comb begin
        wr_en   = 1'b1;
        wr_idx  = hidx;
        wr_word = bd_word_t'(hst_wdata);
        if (!hst_twr) begin
            if (wb_pend[CH_TX]) begin
                wr_idx  = ch_pidx[CH_TX];
                wr_word = ch_pword[CH_TX];
            end else if (wb_pend[CH_RX]) begin
                wr_idx  = ch_pidx[CH_RX];
                wr_word = ch_pword[CH_RX];
            end else begin
                wr_en = 1'b0;
            end
        end
    end

    bdr_table #(.IDX_W(IDX_W)) u_table (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
        .rd_idx(ch_ptr), .rd_word(ch_cur),
        .hrd_idx(hidx), .hrd_word(host_word)
    );

    assign ch_home[CH_TX] = '0;
    assign ch_home[CH_RX] = rx_base;
    assign ch_done        = {rx_done, tx_done};
    assign ch_len[CH_TX]  = tx_len;
    assign ch_len[CH_RX]  = rx_len;

    for (genvar c = 0; c < NCH; c++) begin : g_ring
        localparam int HOME = (c == CH_TX) ? 0 : RST_BASE;
        bdr_ring #(.IDX_W(IDX_W), .RST_HOME(HOME)) u_ring (
            .clk(clk), .rst(rst),
            .home(ch_home[c]),
            .home_load((c == CH_RX) ? base_wr : 1'b0),
            .load_val(hst_wdata[IDX_W-1:0]),
            .cur(ch_cur[c]), .done(ch_done[c]), .done_len(ch_len[c]),
            .gnt(wb_gnt[c]),
            .ptr(ch_ptr[c]), .vld(ch_vld[c]), .pend(wb_pend[c]),
            .pend_idx(ch_pidx[c]), .pend_word(ch_pword[c])
        );
        assign wb_wrap[c] = ch_pword[c].wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hst_ack   <= 1'b0;
            hst_rdata <= '0;
        end else begin
            hst_ack <= hst_sel;
            if (hst_sel && !hst_we)
                hst_rdata <= hst_reg ? 32'(rx_base) : 32'(host_word);
        end
    end

    assign tx_vld   = ch_vld[CH_TX];
    assign tx_desc  = ch_cur[CH_TX];
    assign tx_idx   = ch_ptr[CH_TX];
    assign tx_pause = ch_vld[CH_TX] & ch_cur[CH_TX].pause;
    assign rx_vld   = ch_vld[CH_RX];
    assign rx_desc  = ch_cur[CH_RX];
    assign rx_idx   = ch_ptr[CH_RX];

endmodule

// File: rtl/bdr_chk.sv
`timescale 1ns/1ps
module bdr_chk #(
    parameter int IDX_W    = 8,
    parameter int RST_BASE = 'h80
) (
    input logic             clk,
    input logic             rst,
    input logic             hst_sel,
    input logic             hst_we,
    input logic             hst_reg,
    input logic [31:0]      hst_wdata,
    input logic             hst_ack,
    input logic             hst_twr,
    input logic             tx_vld,
    input logic [31:0]      tx_desc,
    input logic [IDX_W-1:0] tx_idx,
    input logic             tx_done,
    input logic             rx_vld,
    input logic [31:0]      rx_desc,
    input logic [IDX_W-1:0] rx_idx,
    input logic             rx_done,
    input logic [1:0]       wb_pend,
    input logic [1:0]       wb_gnt,
    input logic [1:0]       wb_wrap
);
    AST_RESET_IDX: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tx_idx == '0 && rx_idx == IDX_W'(RST_BASE) && !tx_vld && !rx_vld)); // R1

    AST_ACK_NEXT: assert property (@(posedge clk) disable iff (rst)
        hst_sel |=> hst_ack); // R2

    AST_BASE_MOVES_RX: assert property (@(posedge clk) disable iff (rst)
        (hst_sel && hst_we && hst_reg) |=> rx_idx == $past(hst_wdata[IDX_W-1:0])); // R3

    AST_VLD_NEEDS_RDY: assert property (@(posedge clk) disable iff (rst)
        (tx_vld |-> tx_desc[15]) and (rx_vld |-> rx_desc[15])); // R4

    AST_TX_STEP: assert property (@(posedge clk) disable iff (rst)
        wb_gnt[0] |=> tx_idx == ($past(wb_wrap[0]) ? '0 : IDX_W'($past(tx_idx) + 1'b1))); // R6

    AST_DONE_HIDES: assert property (@(posedge clk) disable iff (rst)
        ((tx_done && tx_vld) |=> !tx_vld) and ((rx_done && rx_vld) |=> !rx_vld)); // R7

    AST_HOST_FIRST: assert property (@(posedge clk) disable iff (rst)
        (hst_twr && wb_pend[0]) |=> ($stable(tx_idx) && wb_pend[0])); // R8

    AST_TX_BEFORE_RX: assert property (@(posedge clk) disable iff (rst)
        (wb_pend == 2'b11 && !hst_twr) |=> wb_pend[1]); // R8

endmodule

bind bdring_ctrl bdr_chk #(.IDX_W(IDX_W), .RST_BASE(RST_BASE)) u_chk (
    .clk(clk), .rst(rst), .hst_sel(hst_sel), .hst_we(hst_we), .hst_reg(hst_reg),
    .hst_wdata(hst_wdata), .hst_ack(hst_ack), .hst_twr(hst_twr),
    .tx_vld(tx_vld), .tx_desc(tx_desc), .tx_idx(tx_idx), .tx_done(tx_done),
    .rx_vld(rx_vld), .rx_desc(rx_desc), .rx_idx(rx_idx), .rx_done(rx_done),
    .wb_pend(wb_pend), .wb_gnt(wb_gnt), .wb_wrap(wb_wrap)
);

// File: tb/sim_bdring_ctrl.sv
`timescale 1ns/1ps
module sim_bdring_ctrl;
    localparam int IDX_W = 8;
    localparam int RB    = 'h80;
    localparam int DEPTH = 1 << IDX_W;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst = 1'b1, hst_sel = 0, hst_we = 0, hst_reg = 0;
    logic [IDX_W+1:0] hst_addr = '0;
    logic [31:0] hst_wdata = '0, hst_rdata, tx_desc, rx_desc;
    logic hst_ack, tx_vld, tx_pause, rx_vld;
    logic tx_done = 0, rx_done = 0;
    logic [15:0] tx_len = '0, rx_len = '0;
    logic [IDX_W-1:0] tx_idx, rx_idx;

    bdring_ctrl #(.IDX_W(IDX_W), .RST_BASE(RB)) u0 (
        .clk(clk), .rst(rst), .hst_sel(hst_sel), .hst_we(hst_we), .hst_reg(hst_reg),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_ack(hst_ack),
        .tx_vld(tx_vld), .tx_desc(tx_desc), .tx_idx(tx_idx), .tx_pause(tx_pause),
        .tx_done(tx_done), .tx_len(tx_len),
        .rx_vld(rx_vld), .rx_desc(rx_desc), .rx_idx(rx_idx),
        .rx_done(rx_done), .rx_len(rx_len)
    );

    logic [31:0] mdl [DEPTH];
    int mptr [2];
    int mbase;
    int nchk = 0, nerr = 0;

    function automatic logic [31:0] retire_m(logic [31:0] w, logic [15:0] l);
        return {l, 1'b0, w[14:0]};
    endfunction

    function automatic int step_m(int p, logic [31:0] w, int home);
        return w[14] ? home : (p + 1) % DEPTH;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic get_ch(input int ch, output logic v, output logic [31:0] d, output int idx);
        v   = ch ? rx_vld  : tx_vld;
        d   = ch ? rx_desc : tx_desc;
        idx = ch ? int'(rx_idx) : int'(tx_idx);
    endtask

    task automatic check_ch(input int ch, input string tag);
        logic v; logic [31:0] d; int idx; logic [31:0] e;
        get_ch(ch, v, d, idx);
        e = mdl[mptr[ch]];
        chk(idx == mptr[ch] && d == e && v == e[15], tag, {v, 7'd0, idx[7:0], d[15:0]},
            {e[15], 7'd0, 8'(mptr[ch]), e[15:0]});
    endtask

    task automatic host_wr(input bit r, input int idx, input logic [31:0] d);
        @(negedge clk);
        hst_sel = 1; hst_we = 1; hst_reg = r; hst_addr = (IDX_W+2)'(idx << 2); hst_wdata = d;
        @(negedge clk);
        hst_sel = 0; hst_we = 0;
        if (r) begin mbase = int'(d[7:0]); mptr[1] = mbase; end
        else mdl[idx] = d;
    endtask

    task automatic host_rd(input bit r, input int idx, output logic [31:0] d);
        @(negedge clk);
        hst_sel = 1; hst_we = 0; hst_reg = r; hst_addr = (IDX_W+2)'(idx << 2);
        @(negedge clk);
        chk(hst_ack == 1'b1, "R2 ack", 32'(hst_ack), 32'd1);
        d = hst_rdata;
        hst_sel = 0;
    endtask

    task automatic set_done(input int ch, input logic v, input logic [15:0] l);
        if (ch) begin rx_done = v; rx_len = l; end
        else    begin tx_done = v; tx_len = l; end
    endtask

    task automatic complete(input int ch, input logic [15:0] l);
        logic v; logic [31:0] d; int idx; int p;
        @(negedge clk);
        get_ch(ch, v, d, idx);
        chk(v == 1'b1, "R4 vld before done", 32'(v), 32'd1);
        set_done(ch, 1, l);
        @(negedge clk);
        set_done(ch, 0, 16'd0);
        get_ch(ch, v, d, idx);
        chk(v == 1'b0, "R7 vld low while pending", 32'(v), 32'd0);
        @(negedge clk);
        p = mptr[ch];
        mptr[ch] = step_m(p, mdl[p], ch ? mbase : 0);
        mdl[p] = retire_m(mdl[p], l);
        check_ch(ch, "R6 step after write-back");
    endtask

    task automatic idle_done(input int ch);
        @(negedge clk);
        set_done(ch, 1, 16'hBEEF);
        @(negedge clk);
        set_done(ch, 0, 16'd0);
        @(negedge clk);
        check_ch(ch, "R5 done ignored when not valid");
    endtask

    initial begin
        #(20 * 150000);
        nerr++;
        $display("FAIL watchdog act=%0d exp=%0d", nchk, 0);
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
        mptr[0] = 0; mptr[1] = RB; mbase = RB;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_ch(0, "R1 tx after reset");
        check_ch(1, "R1 rx after reset");
        host_rd(1, 0, rd);
        chk(rd == 32'h80, "R1 boundary reset", rd, 32'h80);
        host_rd(0, 5, rd);
        chk(rd == 32'h0, "R1 table cleared", rd, 32'h0);

        // transmit ring of four
        for (int s = 0; s < 4; s++)
            host_wr(0, s, {16'(16'h100 + s), 1'b1, s == 3, s == 1, 13'(s)});
        @(negedge clk);
        check_ch(0, "R4 tx desc shown");
        for (int s = 0; s < 4; s++) begin
            if (s == 1) begin
                @(negedge clk);
                chk(tx_pause == 1'b1, "R4 pause bit", 32'(tx_pause), 32'd1);
            end
            complete(0, 16'(16'h40 + s));
        end
        chk(tx_idx == 0 && tx_vld == 0, "R6 tx wrapped", 32'(tx_idx), 32'd0);
        host_rd(0, 2, rd);
        chk(rd == mdl[2] && rd[31:16] == 16'h42 && !rd[15], "R5 write-back word", rd, mdl[2]);

        // receive ring of four at the boundary
        for (int s = 0; s < 4; s++)
            host_wr(0, RB + s, {16'(16'h200 + s), 1'b1, s == 3, 1'b0, 13'(s + 7)});
        for (int s = 0; s < 4; s++) complete(1, 16'(16'h60 + s));
        chk(rx_idx == 8'h80, "R6 rx wrapped to boundary", 32'(rx_idx), 32'h80);
        idle_done(1);
        idle_done(0);

        // boundary reload
        host_wr(1, 0, 32'h40);
        chk(rx_idx == 8'h40, "R3 rx index follows boundary", 32'(rx_idx), 32'h40);
        host_rd(1, 0, rd);
        chk(rd == 32'h40, "R3 boundary readback", rd, 32'h40);

        // host write against a pending write-back
        host_wr(0, 0, {16'h0011, 1'b1, 1'b0, 1'b0, 13'd0});
        host_wr(0, 1, {16'h0012, 1'b1, 1'b0, 1'b0, 13'd1});
        host_wr(0, 'h40, {16'h0013, 1'b1, 1'b0, 1'b0, 13'd2});
        host_wr(0, 'h41, {16'h0014, 1'b1, 1'b0, 1'b0, 13'd3});
        @(negedge clk);
        tx_done = 1; tx_len = 16'h0077;
        @(negedge clk);
        tx_done = 0;
        hst_sel = 1; hst_we = 1; hst_reg = 0; hst_addr = (IDX_W+2)'('h30 << 2); hst_wdata = 32'hCAFE_0123;
        @(negedge clk);
        hst_sel = 0; hst_we = 0;
        mdl['h30] = 32'hCAFE_0123;
        chk(tx_idx == 0 && tx_vld == 0, "R8 write-back held by host write", 32'(tx_idx), 32'd0);
        @(negedge clk);
        mdl[0] = retire_m(mdl[0], 16'h0077); mptr[0] = 1;
        check_ch(0, "R8 write-back lands after host");

        // both directions complete together
        @(negedge clk);
        tx_done = 1; tx_len = 16'h0088; rx_done = 1; rx_len = 16'h0099;
        @(negedge clk);
        tx_done = 0; rx_done = 0;
        @(negedge clk);
        mdl[1] = retire_m(mdl[1], 16'h0088); mptr[0] = 2;
        check_ch(0, "R8 tx written first");
        chk(rx_idx == 8'h40 && rx_vld == 0, "R8 rx waits one cycle", 32'(rx_idx), 32'h40);
        @(negedge clk);
        mdl['h40] = retire_m(mdl['h40], 16'h0099); mptr[1] = 'h41;
        check_ch(1, "R8 rx written next");

        // close both rings at slot 3, then random traffic
        host_wr(0, 3, {16'h0, 1'b0, 1'b1, 1'b0, 13'd0});
        host_wr(0, 'h43, {16'h0, 1'b0, 1'b1, 1'b0, 13'd0});
        for (int it = 0; it < 400; it++) begin
            int op, ch, s, home;
            op = int'($urandom % 3); ch = int'($urandom % 2);
            home = ch ? mbase : 0;
            if (op == 0) begin
                s = int'($urandom % 4);
                host_wr(0, home + s, {16'($urandom), 1'($urandom), s == 3, 1'($urandom), 13'($urandom)});
                @(negedge clk);
                check_ch(ch, "R4 random descriptor");
            end else if (op == 1) begin
                if (mdl[mptr[ch]][15]) complete(ch, 16'($urandom));
                else idle_done(ch);
            end else begin
                s = int'($urandom % 4);
                host_rd(0, home + s, rd);
                chk(rd == mdl[home + s], "R2 random readback", rd, mdl[home + s]);
            end
        end
        check_ch(0, "R6 final tx");
        check_ch(1, "R6 final rx");

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule